// File: doc/BRIEF.md
# Port-Driven Branch Condition Unit

This unit decides whether a conditional call or conditional jump is taken in a small microcontroller core. It keeps two condition flags. The first follows the pad level of bit 0 of a 16-bit general-purpose port. The second follows the pad level of bit 1, unless a control bit hands that flag to an external comparator result. The pad level is what the bench or the outside world drives on an input pin, or the core's own driven level on an output pin, so both flags stay meaningful in either direction.

The instruction decoder presents a valid flag and a 3-bit operation code. One clock later the unit returns a registered take decision and a one-cycle call strobe or jump strobe. A small register window sets up the port. It holds the output data, the per-bit direction and the comparator-enable bit. Reading the data location returns the live port state.

Top module: `brcond_unit`

## Requirements
- R1: After a synchronous reset the data, direction and control registers are all zero, so `pin_out` and `pin_oe` are 0, and `take`, `call_stb` and `jump_stb` are low.
- R2: A write with `reg_wr` high stores `reg_wdata` at byte address 0 (port data), 2 (direction, 1 = output) or 4 (control, bit 0 = comparator enable). A write to any other address changes no register. `reg_rdata` shows the register at `reg_addr` one clock after the address is presented.
- R3: Reading address 0 returns the latched data for each bit whose direction is 1. For each bit whose direction is 0, it returns the pin level as it stood two clocks earlier.
- R4: Condition 1 is the pad level of port bit 0. The pad level is the data bit when direction bit 0 is 1, and `pin_in[0]` otherwise. When the bit is an output, `pin_in[0]` has no effect.
- R5: Condition 2 is the pad level of port bit 1 when control bit 0 is 0, and `cmp_result` when it is 1.
- R6: `instr_op` encoding: bit 2 selects the condition (0 = condition 1, 1 = condition 2), bit 1 selects jump (1) or call (0), and bit 0 marks the negated form. A non-negated form is taken when its condition is 1 and ignored when it is 0.
- R7: A negated form is taken when its condition is 0 and ignored when it is 1.
- R8: For an instruction sampled with `instr_valid` high, `take` and then either `call_stb` (call forms) or `jump_stb` (jump forms) are high in the next cycle if the instruction is taken. All three are low after an ignored instruction or a cycle without `instr_valid`. The two strobes are never high together.
- R9: Pad levels and `cmp_result` pass through two synchronizing flops. An instruction sampled at the first or second clock edge after a pin change still sees the old level. One sampled at the third edge sees the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Levels seen on the port pins |
| pin_out | output | 16 | Driven port data |
| pin_oe | output | 16 | Per-bit output enable |
| cmp_result | input | 1 | Comparator result |
| instr_valid | input | 1 | Conditional instruction present |
| instr_op | input | 3 | Condition select, jump/call, negate |
| take | output | 1 | Registered take decision |
| call_stb | output | 1 | Call taken pulse |
| jump_stb | output | 1 | Jump taken pulse |

## Verification
The assertions check several rules on every cycle: the two strobes are mutually exclusive, an idle cycle leaves every strobe low, a taken/ignored verdict follows the condition and the negate bit, and a register write lands in the addressed location and nowhere else. Some behaviour only the bench scenarios can show. These cover the choice of condition source between input pin, driven output and comparator. They also cover the exact two-flop latency after a pin change and the merged read-back of the data location.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_DIR  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 3'd4;

  typedef struct packed {
    logic cond_sel;  // 0: condition 1, 1: condition 2
    logic is_jump;   // 0: call, 1: jump
    logic negate;    // 1: taken on false
  } br_op_t;
endpackage

// File: rtl/brcond_sync.sv
module brcond_sync #(
  parameter int unsigned W      = 17,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/brcond_regs.sv
module brcond_regs
  import brcond_pkg::*;
#(
  parameter int unsigned PORT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0]     wdata,
  input  logic [PORT_W-1:0]     pad_sync,
  output logic [PORT_W-1:0]     data_q,
  output logic [PORT_W-1:0]     dir_q,
  output logic                  cmp_en,
  output logic [PORT_W-1:0]     rdata
);
  logic [PORT_W-1:0] port_view;
  logic [PORT_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      cmp_en <= 1'b0;
    end else if (wr) begin
      case (addr)
        ADDR_DATA: data_q <= wdata;
        ADDR_DIR:  dir_q  <= wdata;
        ADDR_CTRL: cmp_en <= wdata[0];
        default:   ;
      endcase
    end
  end

  assign port_view = (dir_q & data_q) | (~dir_q & pad_sync);

  always_comb begin
    case (addr)
      ADDR_DATA: rd_next = port_view;
      ADDR_DIR:  rd_next = dir_q;
      ADDR_CTRL: rd_next = {{(PORT_W-1){1'b0}}, cmp_en};
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr && addr == ADDR_DATA |=> data_q == $past(wdata)); // R2
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr && addr == ADDR_DIR |=> dir_q == $past(wdata)); // R2
  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    wr && addr != ADDR_DATA && addr != ADDR_DIR && addr != ADDR_CTRL
    |=> $stable(data_q) && $stable(dir_q) && $stable(cmp_en)); // R2
endmodule

// File: rtl/brcond_decide.sv
module brcond_decide
  import brcond_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   valid,
  input  br_op_t op,
  input  logic   cond1,
  input  logic   cond2,
  output logic   take,
  output logic   call_stb,
  output logic   jump_stb
);
  logic cond_pick;
  logic hit;

  assign cond_pick = op.cond_sel ? cond2 : cond1;
  assign hit       = valid & (cond_pick ^ op.negate);

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      call_stb <= 1'b0;
      jump_stb <= 1'b0;
    end else begin
      take     <= hit;
      call_stb <= hit & ~op.is_jump;
      jump_stb <= hit &  op.is_jump;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(call_stb && jump_stb)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !take && !call_stb && !jump_stb); // R8
  AST_TRUE_FORM: assert property (@(posedge clk) disable iff (rst)
    valid && !op.negate |=> take == $past(op.cond_sel ? cond2 : cond1)); // R6
  AST_NEG_FORM: assert property (@(posedge clk) disable iff (rst)
    valid && op.negate |=> take == !$past(op.cond_sel ? cond2 : cond1)); // R7
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int unsigned PORT_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [PORT_W-1:0]     reg_wdata,
  output logic [PORT_W-1:0]     reg_rdata,
  input  logic [PORT_W-1:0]     pin_in,
  output logic [PORT_W-1:0]     pin_out,
  output logic [PORT_W-1:0]     pin_oe,
  input  logic                  cmp_result,
  input  logic                  instr_valid,
  input  logic [2:0]            instr_op,
  output logic                  take,
  output logic                  call_stb,
  output logic                  jump_stb
);
  localparam int unsigned SYNC_W = PORT_W + 1;

  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] dir_q;
  logic              cmp_en;
  logic [PORT_W-1:0] pad_level;
  logic [SYNC_W-1:0] sync_q;
  logic              cond1;
  logic              cond2;

  assign pad_level = (dir_q & data_q) | (~dir_q & pin_in);
  assign pin_out   = data_q;
  assign pin_oe    = dir_q;

  brcond_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cmp_result, pad_level}),
    .q   (sync_q)
  );

  brcond_regs #(.PORT_W(PORT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .pad_sync (sync_q[PORT_W-1:0]),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .cmp_en   (cmp_en),
    .rdata    (reg_rdata)
  );

  assign cond1 = sync_q[0];
  assign cond2 = cmp_en ? sync_q[PORT_W] : sync_q[1];

  brcond_decide u_decide (
    .clk      (clk),
    .rst      (rst),
    .valid    (instr_valid),
    .op       (br_op_t'(instr_op)),
    .cond1    (cond1),
    .cond2    (cond2),
    .take     (take),
    .call_stb (call_stb),
    .jump_stb (jump_stb)
  );

  AST_CALL_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
    (call_stb || jump_stb) |-> take); // R8
endmodule

// File: tb/brcond_unit_bench.sv
module brcond_unit_bench;
  localparam int unsigned PORT_W = 16;
  localparam int unsigned NVEC   = 16;

  // [12:11] pin_in[1:0], [10:9] dir[1:0], [8:7] data[1:0], [6] cmp enable,
  // [5] cmp_result, [4:2] op, [1] expected call, [0] expected jump
  localparam logic [12:0] VEC [NVEC] = '{
    {2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 3'b000, 2'b10},  // R6 call c1 true
    {2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 3'b001, 2'b00},  // R7 ncall c1 true
    {2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 3'b001, 2'b10},  // R7 ncall c1 false
    {2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 3'b010, 2'b00},  // R6 jump c1 false
    {2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 3'b010, 2'b01},  // R6 jump c1 true
    {2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 3'b011, 2'b01},  // R7 njump c1 false
    {2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 3'b100, 2'b10},  // R6 call c2 true
    {2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 3'b111, 2'b00},  // R7 njump c2 true
    {2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 3'b111, 2'b01},  // R7 njump c2 false
    {2'b00, 2'b01, 2'b01, 1'b0, 1'b0, 3'b000, 2'b10},  // R4 output drives 1
    {2'b01, 2'b01, 2'b00, 1'b0, 1'b0, 3'b010, 2'b00},  // R4 output 0 masks pin
    {2'b10, 2'b00, 2'b00, 1'b1, 1'b0, 3'b110, 2'b00},  // R5 cmp overrides pin
    {2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 3'b100, 2'b10},  // R5 cmp true
    {2'b00, 2'b10, 2'b10, 1'b0, 1'b0, 3'b110, 2'b01},  // R4 c2 from output
    {2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 3'b101, 2'b00},  // R5 ncall cmp true
    {2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 3'b011, 2'b00}   // R7 njump c1 true
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [PORT_W-1:0] reg_wdata = '0;
  logic [PORT_W-1:0] reg_rdata;
  logic [PORT_W-1:0] pin_in = '0;
  logic [PORT_W-1:0] pin_out;
  logic [PORT_W-1:0] pin_oe;
  logic              cmp_result = 1'b0;
  logic              instr_valid = 1'b0;
  logic [2:0]        instr_op = '0;
  logic              take;
  logic              call_stb;
  logic              jump_stb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  brcond_unit u_brcond_unit (
    .clk (clk), .rst (rst),
    .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe),
    .cmp_result (cmp_result),
    .instr_valid (instr_valid), .instr_op (instr_op),
    .take (take), .call_stb (call_stb), .jump_stb (jump_stb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [PORT_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [PORT_W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    logic [PORT_W-1:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 strobes", {29'b0, take, call_stb, jump_stb}, 32'h0);
    read_reg(3'd4, rd);
    check("R1 ctrl", 32'(rd), 32'h0);

    // R2 writes and readback, bad address ignored
    write_reg(3'd2, 16'hA5A5);
    read_reg(3'd2, rd);
    check("R2 dir readback", 32'(rd), 32'hA5A5);
    check("R2 pin_oe", 32'(pin_oe), 32'hA5A5);
    write_reg(3'd0, 16'h1234);
    check("R2 pin_out", 32'(pin_out), 32'h1234);
    write_reg(3'd6, 16'hFFFF);
    write_reg(3'd1, 16'hFFFF);
    check("R2 bad addr data", 32'(pin_out), 32'h1234);
    check("R2 bad addr dir", 32'(pin_oe), 32'hA5A5);
    read_reg(3'd4, rd);
    check("R2 bad addr ctrl", 32'(rd), 32'h0);

    // R3 merged read of the data location
    write_reg(3'd2, 16'h00FF);
    pin_in = 16'hAB00;
    repeat (3) @(negedge clk);
    read_reg(3'd0, rd);
    check("R3 data view", 32'(rd), 32'hAB34);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [12:0] v;
      v = VEC[i];
      write_reg(3'd0, {14'b0, v[8:7]});
      write_reg(3'd2, {14'b0, v[10:9]});
      write_reg(3'd4, {15'b0, v[6]});
      pin_in = {14'b0, v[12:11]};
      cmp_result = v[5];
      repeat (3) @(negedge clk);
      instr_valid = 1'b1; instr_op = v[4:2];
      @(negedge clk);
      instr_valid = 1'b0;
      check(v[2] ? "R7 strobes" : "R6 strobes", {30'b0, call_stb, jump_stb}, {30'b0, v[1:0]});
      check("R8 take", {31'b0, take}, {31'b0, v[1] | v[0]});
      @(negedge clk);
      check("R8 pulse ends", {29'b0, take, call_stb, jump_stb}, 32'h0);
    end

    // R9 synchronizer latency
    write_reg(3'd0, 16'h0);
    write_reg(3'd2, 16'h0);
    write_reg(3'd4, 16'h0);
    pin_in = '0;
    repeat (3) @(negedge clk);
    pin_in[0] = 1'b1; instr_valid = 1'b1; instr_op = 3'b000;
    @(negedge clk);
    check("R9 edge1 old", {31'b0, call_stb}, 32'h0);
    @(negedge clk);
    check("R9 edge2 old", {31'b0, call_stb}, 32'h0);
    @(negedge clk);
    check("R9 edge3 new", {31'b0, call_stb}, 32'h1);
    instr_valid = 1'b0;
    @(negedge clk);
    check("R8 no valid", {29'b0, take, call_stb, jump_stb}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule